// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one memory access may go ahead under a set of protection regions. Each region comes in already decoded: an inclusive lower and upper byte address, an active flag and a configuration byte that carries read, write and execute permissions plus a lock bit. The access request gives a start address, a byte count, the permissions it needs and the privilege mode it runs in. From these the block returns a grant bit, the permission set that applied, the index of the deciding region and a flag that says no region matched.

Regions are scanned with fixed priority, lowest index first. The first active region that contains either the first or the last byte of the access decides. If it contains only one of the two bytes, the access straddles a boundary and is denied outright. Machine mode ignores the permissions of unlocked regions and passes when nothing matches; every other mode fails when nothing matches. The decision path is combinational. A parameter adds one output register stage.

Top module: `pmp_access_checker`

## Requirements
- R1: A region matches when it is active and both the first byte (`acc_addr`) and the last byte (`acc_addr + size - 1`) lie within its inclusive bounds. The matching region's index appears on `hit_idx`, and `no_hit` is 0.
- R2: When several active regions contain the access, the one with the lowest index decides.
- R3: If the deciding region contains exactly one of the first and last bytes, the result is a denial with `perm` = 0. `hit_idx` then names that region, and higher-index regions have no influence.
- R4: In machine mode (`acc_mode` = 3) with a matching region whose lock bit (configuration bit 7) is 0, `perm` is 3'b111.
- R5: In any other mode, or when the matching region is locked, `perm` equals configuration bits [2:0] of that region: bit 0 read, bit 1 write, bit 2 execute.
- R6: `grant` is 1 exactly when every bit set in `acc_need` (same bit order as `perm`) is also set in `perm`.
- R7: When no active region contains either byte, `no_hit` is 1 and `hit_idx` is 0. Machine mode then gets `grant` = 1 with `perm` = 3'b111. Other modes get `grant` = 0 with `perm` = 0.
- R8: Regions with their active flag at 0 take no part in matching, even if their bounds contain the access.
- R9: An `acc_size` of 0 stands for ADDR_W/8 bytes.
- R10: An access whose last byte would lie beyond the top of the address space has its last byte outside every region.
- R11: With OUT_REG = 1, the outputs show the decision for the inputs present at the previous rising clock edge. During reset the outputs are `grant` = 0, `perm` = 0, `hit_idx` = 0 and `no_hit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bound per region, region i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive upper bound per region |
| ent_active | input | NUM_ENTRIES | Region takes part in matching when 1 |
| ent_cfg | input | NUM_ENTRIES*8 | Configuration byte per region: [0] read, [1] write, [2] execute, [7] lock |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | SIZE_W | Access length in bytes, 0 meaning ADDR_W/8 |
| acc_need | input | 3 | Permissions the access needs |
| acc_mode | input | 2 | Privilege mode, 3 being machine mode |
| grant | output | 1 | Access allowed |
| perm | output | 3 | Permission set that applied |
| hit_idx | output | IDX_W | Index of the deciding region |
| no_hit | output | 1 | No region matched |

## Verification
Two functions can decide in the same cycle: the lowest-index priority pick and the straddle rejection. This happens when one access ends past the edge of a low region while a higher region holds it entirely. The bench builds this with overlapping regions and an access that crosses the low region's top, and it expects a denial naming the low region rather than a grant from the higher one. A second pairing sets the machine-mode exemption against the lock bit on the same access and checks that the lock wins.

// File: rtl/pmp_chk_pkg.sv
// Package: shared constants for the protection checker.
// Assumes: configuration byte keeps permissions in [2:0] and lock in [7].
package pmp_chk_pkg;
    localparam logic [1:0] MODE_MACHINE = 2'd3;
    localparam int unsigned CFG_LOCK_BIT = 7;
    localparam logic [2:0] PERM_ALL = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/pmp_span_calc.sv
// Module: computes the last byte address of an access.
// Assumes: size 0 means a register-wide access of ADDR_W/8 bytes. The sum is
// one bit wider so that a carry flags an access running past the top.
module pmp_span_calc #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] last,
    output logic              wrap
);
    localparam int DEF_BYTES = ADDR_W / 8;

    logic [ADDR_W:0] eff_len;
    logic [ADDR_W:0] last_ext;

    // Pick the effective length and add it to the start address.
    always_comb begin
        eff_len  = (size == '0) ? (ADDR_W+1)'(DEF_BYTES) : (ADDR_W+1)'(size);
        last_ext = {1'b0, addr} + eff_len - (ADDR_W+1)'(1);
        last     = last_ext[ADDR_W-1:0];
        wrap     = last_ext[ADDR_W];
    end
endmodule

// File: rtl/pmp_entry_match.sv
// Module: per-region containment test of the first and last access bytes.
// Assumes: bounds are inclusive; inactive regions never contain anything.
module pmp_entry_match #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32
) (
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
    input  logic [NUM_ENTRIES-1:0]        ent_active,
    input  logic [ADDR_W-1:0]             first_b,
    input  logic [ADDR_W-1:0]             last_b,
    input  logic                          last_wrap,
    output logic [NUM_ENTRIES-1:0]        head_in,
    output logic [NUM_ENTRIES-1:0]        tail_in
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic [ADDR_W-1:0] lo_b;
        logic [ADDR_W-1:0] hi_b;
        assign lo_b = ent_lo[g*ADDR_W +: ADDR_W];
        assign hi_b = ent_hi[g*ADDR_W +: ADDR_W];

        // Compare both access ends against this region's bounds.
        always_comb begin
            head_in[g] = ent_active[g] && (first_b >= lo_b) && (first_b <= hi_b);
            tail_in[g] = ent_active[g] && !last_wrap &&
                         (last_b >= lo_b) && (last_b <= hi_b);
        end
    end
endmodule

// File: rtl/pmp_prio_pick.sv
// Module: fixed-priority pick of the lowest region touching the access.
// Assumes: head_in/tail_in are already gated by the active flags.
module pmp_prio_pick #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] head_in,
    input  logic [NUM_ENTRIES-1:0] tail_in,
    output logic                   any_hit,
    output logic                   partial,
    output logic [IDX_W-1:0]       idx,
    output logic [NUM_ENTRIES-1:0] sel
);
    logic [NUM_ENTRIES-1:0] touch;

    assign touch = head_in | tail_in;

    // Scan from index 0 upward; the first touching region wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        any_hit = 1'b0;
        partial = 1'b0;
        idx     = '0;
        sel     = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!found && touch[i]) begin
                found   = 1'b1;
                any_hit = 1'b1;
                partial = head_in[i] ^ tail_in[i];
                idx     = IDX_W'(i);
                sel[i]  = 1'b1;
            end
        end
    end

    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2
    winner_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((touch & (sel - NUM_ENTRIES'(1))) == '0));

    // R3
    partial_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partial |-> any_hit);
endmodule

// File: rtl/pmp_perm_resolve.sv
// Module: turns the picked region and mode into a permission set and grant.
// Assumes: cfg is the configuration byte of the picked region (don't care
// when any_hit is 0).
module pmp_perm_resolve (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_hit,
    input  logic       partial,
    input  logic [7:0] cfg,
    input  logic [1:0] mode,
    input  logic [2:0] need,
    output logic       grant,
    output logic [2:0] perm
);
    import pmp_chk_pkg::*;

    logic is_mach;
    logic locked;

    assign is_mach = (mode == MODE_MACHINE);
    assign locked  = cfg[CFG_LOCK_BIT];

    // Choose the applicable permissions, then test the requested ones.
    always_comb begin
        if (!any_hit) begin
            perm = is_mach ? PERM_ALL : PERM_NONE;
        end else if (partial) begin
            perm = PERM_NONE;
        end else if (is_mach && !locked) begin
            perm = PERM_ALL;
        end else begin
            perm = cfg[2:0];
        end
        grant = ((need & ~perm) == 3'b000) && !(any_hit && partial) &&
                (any_hit || is_mach);
    end

    // R3
    straddle_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && partial) |-> (!grant && perm == 3'b000));

    // R6
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((need & ~perm) == 3'b000));

    // R7
    nomatch_user_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && mode != 2'd3) |-> !grant);

    // R7
    nomatch_mach_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && mode == 2'd3) |-> (grant && perm == 3'b111));

    // R5
    locked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !partial && cfg[7]) |-> (perm == cfg[2:0]));
endmodule

// File: rtl/pmp_access_checker.sv
// Module: top of the protection access checker.
// Assumes: bounds arrive decoded; regions are flat-packed by index; the
// output register is present only when OUT_REG is 1.
module pmp_access_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 8,
    parameter bit OUT_REG     = 1'b0,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
    input  logic [NUM_ENTRIES-1:0]        ent_active,
    input  logic [NUM_ENTRIES*8-1:0]      ent_cfg,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [SIZE_W-1:0]             acc_size,
    input  logic [2:0]                    acc_need,
    input  logic [1:0]                    acc_mode,
    output logic                          grant,
    output logic [2:0]                    perm,
    output logic [IDX_W-1:0]              hit_idx,
    output logic                          no_hit
);
    logic [ADDR_W-1:0]      last_b;
    logic                   last_wrap;
    logic [NUM_ENTRIES-1:0] head_in;
    logic [NUM_ENTRIES-1:0] tail_in;
    logic                   any_hit;
    logic                   partial;
    logic [IDX_W-1:0]       pick_idx;
    logic [NUM_ENTRIES-1:0] pick_sel;
    logic [7:0]             pick_cfg;
    logic                   grant_c;
    logic [2:0]             perm_c;

    pmp_span_calc #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_span (
        .addr (acc_addr),
        .size (acc_size),
        .last (last_b),
        .wrap (last_wrap)
    );

    pmp_entry_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .ent_lo     (ent_lo),
        .ent_hi     (ent_hi),
        .ent_active (ent_active),
        .first_b    (acc_addr),
        .last_b     (last_b),
        .last_wrap  (last_wrap),
        .head_in    (head_in),
        .tail_in    (tail_in)
    );

    pmp_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .head_in (head_in),
        .tail_in (tail_in),
        .any_hit (any_hit),
        .partial (partial),
        .idx     (pick_idx),
        .sel     (pick_sel)
    );

    // Fetch the configuration byte of the selected region (one-hot OR mux).
    always_comb begin
        pick_cfg = 8'h00;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            pick_cfg = pick_cfg | (ent_cfg[i*8 +: 8] & {8{pick_sel[i]}});
        end
    end

    pmp_perm_resolve u_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_hit (any_hit),
        .partial (partial),
        .cfg     (pick_cfg),
        .mode    (acc_mode),
        .need    (acc_need),
        .grant   (grant_c),
        .perm    (perm_c)
    );

    if (OUT_REG) begin : g_reg
        // Hold the decision for one cycle; reset to a no-match denial.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grant   <= 1'b0;
                perm    <= 3'b000;
                hit_idx <= '0;
                no_hit  <= 1'b1;
            end else begin
                grant   <= grant_c;
                perm    <= perm_c;
                hit_idx <= pick_idx;
                no_hit  <= !any_hit;
            end
        end
    end else begin : g_comb
        // Pass the decision straight through.
        always_comb begin
            grant   = grant_c;
            perm    = perm_c;
            hit_idx = pick_idx;
            no_hit  = !any_hit;
        end
    end

    // R7
    nohit_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_hit |-> (hit_idx == '0));
endmodule

// File: tb/test_pmp_access_checker.sv
module test_pmp_access_checker;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int SW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*AW-1:0] ent_lo, ent_hi;
    logic [N-1:0]    ent_active;
    logic [N*8-1:0]  ent_cfg;
    logic [AW-1:0]   acc_addr = '0;
    logic [SW-1:0]   acc_size = '0;
    logic [2:0]      acc_need = '0;
    logic [1:0]      acc_mode = '0;
    logic            grant;
    logic [2:0]      perm;
    logic [IW-1:0]   hit_idx;
    logic            no_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic          g;
        logic [2:0]    p;
        logic [IW-1:0] idx;
        logic          nh;
        string         tag;
    } exp_t;
    exp_t sb[$];

    logic [AW-1:0] lo_a [N];
    logic [AW-1:0] hi_a [N];
    logic [7:0]    cfg_a [N];

    always #5 clk = ~clk;

    pmp_access_checker #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .OUT_REG(1'b1))
        i_pmp_access_checker (
        .clk(clk), .rst_n(rst_n), .ent_lo(ent_lo), .ent_hi(ent_hi),
        .ent_active(ent_active), .ent_cfg(ent_cfg), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_need(acc_need), .acc_mode(acc_mode),
        .grant(grant), .perm(perm), .hit_idx(hit_idx), .no_hit(no_hit)
    );

    // Pack the region arrays onto the flat ports.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_lo[i*AW +: AW] = lo_a[i];
            ent_hi[i*AW +: AW] = hi_a[i];
            ent_cfg[i*8 +: 8]  = cfg_a[i];
        end
    end

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [AW-1:0] a, input logic [SW-1:0] s,
                                   input logic [2:0] need, input logic [1:0] m,
                                   input string tag);
        exp_t e;
        logic [AW:0] endx;
        logic [AW:0] n;
        bit h, t;
        n = (s == 0) ? (AW+1)'(AW/8) : (AW+1)'(s);
        endx = {1'b0, a} + n - 1;
        e.g = (m == 2'd3); e.p = (m == 2'd3) ? 3'b111 : 3'b000;
        e.idx = '0; e.nh = 1'b1; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            h = ent_active[i] && a >= lo_a[i] && a <= hi_a[i];
            t = ent_active[i] && endx[AW] == 1'b0 &&
                endx[AW-1:0] >= lo_a[i] && endx[AW-1:0] <= hi_a[i];
            if (h || t) begin
                e.nh = 1'b0; e.idx = IW'(i);
                if (h != t) begin
                    e.p = 3'b000; e.g = 1'b0;
                end else begin
                    e.p = (m == 2'd3 && !cfg_a[i][7]) ? 3'b111 : cfg_a[i][2:0];
                    e.g = ((need & ~e.p) == 3'b000);
                end
                return e;
            end
        end
        return e;
    endfunction

    // Driver: apply one access at the falling edge and queue its expectation.
    task automatic drive(input logic [AW-1:0] a, input logic [SW-1:0] s,
                         input logic [2:0] need, input logic [1:0] m, input string tag);
        acc_addr = a; acc_size = s; acc_need = need; acc_mode = m;
        sb.push_back(model(a, s, need, m, tag));
        @(negedge clk);
    endtask

    task automatic compare(input exp_t e);
        checks++;
        if (grant !== e.g || perm !== e.p || hit_idx !== e.idx || no_hit !== e.nh) begin
            errors++;
            $display("FAIL %s: got grant=%0b perm=%03b idx=%0d no_hit=%0b, exp grant=%0b perm=%03b idx=%0d no_hit=%0b",
                     e.tag, grant, perm, hit_idx, no_hit, e.g, e.p, e.idx, e.nh);
        end
    endtask

    // Monitor: one registered result per rising edge (R11 latency).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        exp_t r;
        lo_a[0] = 32'h0000_1000; hi_a[0] = 32'h0000_1FFF; cfg_a[0] = 8'h01;
        lo_a[1] = 32'h0000_1800; hi_a[1] = 32'h0000_27FF; cfg_a[1] = 8'h83;
        lo_a[2] = 32'h0000_4000; hi_a[2] = 32'h0000_4FFF; cfg_a[2] = 8'h04;
        lo_a[3] = 32'hFFFF_F000; hi_a[3] = 32'hFFFF_FFFF; cfg_a[3] = 8'h07;
        ent_active = 4'b1011;
        acc_mode = 2'd3; acc_addr = 32'h0000_1100; acc_size = 8'd4;
        repeat (3) @(negedge clk);
        // R11: reset values while the inputs would give a machine-mode grant
        r.g = 1'b0; r.p = 3'b000; r.idx = '0; r.nh = 1'b1; r.tag = "R11 reset";
        compare(r);
        rst_n = 1'b1;
        @(negedge clk);

        drive(32'h0000_1100, 8'd4, 3'b001, 2'd0, "R1 R5 user read region0");
        drive(32'h0000_1100, 8'd4, 3'b010, 2'd0, "R6 user write denied");
        drive(32'h0000_1100, 8'd4, 3'b010, 2'd3, "R4 machine unlocked all");
        drive(32'h0000_1900, 8'd4, 3'b010, 2'd0, "R2 lowest index wins");
        drive(32'h0000_1FFE, 8'd4, 3'b001, 2'd3, "R3 straddle denies");
        drive(32'h0000_2100, 8'd4, 3'b011, 2'd0, "R5 user read-write region1");
        drive(32'h0000_2100, 8'd4, 3'b100, 2'd3, "R4 R5 locked binds machine");
        drive(32'h0000_4100, 8'd4, 3'b100, 2'd1, "R8 R7 inactive user fail");
        drive(32'h0000_4100, 8'd4, 3'b100, 2'd3, "R8 R7 inactive machine pass");
        drive(32'h0000_1FFC, 8'd0, 3'b001, 2'd0, "R9 size zero fits");
        drive(32'h0000_1FFD, 8'd0, 3'b001, 2'd0, "R9 size zero straddles");
        drive(32'hFFFF_FFFE, 8'd4, 3'b001, 2'd0, "R10 wrap past top");
        drive(32'hFFFF_FFF0, 8'd16, 3'b111, 2'd1, "R1 ends on top byte");
        ent_active = 4'b1111;
        drive(32'h0000_4100, 8'd4, 3'b100, 2'd0, "R8 activated exec");
        drive(32'h0000_4FFF, 8'd1, 3'b001, 2'd0, "R6 single byte read on exec");
        ent_active = 4'b0000;
        drive(32'h0000_1100, 8'd4, 3'b001, 2'd2, "R7 none active user");
        drive(32'h0000_1100, 8'd4, 3'b111, 2'd3, "R7 none active machine");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule